// File: doc/BRIEF.md
# Split-Read Seconds Counter

This block keeps a 48-bit count of elapsed seconds. Its time base is a slow tick of nominally 32768 Hz, arriving asynchronously to the bus clock. The tick passes through a synchronizer and is turned into one bus-clock pulse per rising edge. A prescaler of `PRE_W` bits (15 by default) divides those pulses down to one second. Software sees the count through a 32-bit register port as two words: the low 32 bits and the upper 16 bits.

Writes to either word do not land at once. The value is staged and a per-word pending flag is raised. The value is committed to the counter on the second slow tick after the write, and the flag then drops. Software polls the pending register until it reads zero.

A two-bit freeze mode makes split reads coherent. In freeze mode a read of the low word copies the upper word into a shadow, and the next read of the upper word returns that shadow and releases it. A carry between the two reads then cannot tear the value. Software must read the low word first.

Top module: `sec_counter_split`

## Requirements
- R1: After reset the count, the prescaler, both pending flags and the freeze mode are zero, and `bus_rvalid_o` is low.
- R2: The count changes only on a synchronized slow-tick edge, and it advances by one when the prescaler wraps, that is after every 2^PRE_W tick edges.
- R3: The count is 48 bits wide and wraps from all ones to zero.
- R4: A write to the low word (address 0x08) sets pending bit 0, and a write to the high word (address 0x0C) sets pending bit 1. The pending flags read as bits 1:0 of address 0x68; nothing but such a write sets them.
- R5: A staged word reaches the count, and its pending bit clears, on the second slow-tick edge after the write; until then reads return the old value.
- R6: Bits 31:16 of a high-word write are ignored, and a high-word read returns zero in bits 31:16.
- R7: Committing a low word restarts the prescaler at zero, so the next second takes a full 2^PRE_W tick edges.
- R8: The freeze mode is bits 25:24 of address 0x50 and reads back there. With mode 2, a low-word read captures the upper 16 bits. The next high-word read returns the captured value and releases it.
- R9: With any other mode, a high-word read returns the live upper bits.
- R10: Read data appears on `bus_rdata_o` with `bus_rvalid_o` high in the cycle after the read request; unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick_i | input | 1 | Asynchronous 32768 Hz time base |
| bus_rd_i | input | 1 | Read request |
| bus_wr_i | input | 1 | Write request |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data |
| bus_rvalid_o | output | 1 | Read data valid |

## Verification
The hardest case to reach from the ports is a carry out of the low word that falls between the low read and the high read, because only that case shows whether freeze mode keeps the value coherent. The stimulus reaches it by loading 0xFFFFFFFF into the low word and waiting for the commit, which also restarts the prescaler. It then reads the low word and drives exactly one second of tick edges, so the carry is certain to fall before the high read. The same sequence with freeze mode off shows the live, torn value instead.

// File: rtl/sec_counter_split.sv
module sec_counter_split #(
  parameter int PRE_W  = 15,
  parameter int SEC_W  = 48,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              bus_rvalid_o
);
  localparam int HI_W = SEC_W - 32;
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(8'h50);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(8'h68);
  localparam logic [1:0] MODE_FREEZE = 2'd2;

  logic [2:0]       tk_sync;
  logic             tick;
  logic [SEC_W-1:0] sec_q, sec_nxt;
  logic [PRE_W-1:0] pre_q, pre_nxt;
  logic [31:0]      stage_lo;
  logic [HI_W-1:0]  stage_hi, shadow_q;
  logic             pend_lo, pend_hi, seen_lo, seen_hi;
  logic             commit_lo, commit_hi, frozen_q;
  logic [1:0]       mode_q;
  logic             wr_lo, wr_hi, wr_ctl, rd_lo, rd_hi;

  assign tick      = tk_sync[1] & ~tk_sync[2];
  assign wr_lo     = bus_wr_i && (bus_addr_i == A_LO);
  assign wr_hi     = bus_wr_i && (bus_addr_i == A_HI);
  assign wr_ctl    = bus_wr_i && (bus_addr_i == A_CTL);
  assign rd_lo     = bus_rd_i && (bus_addr_i == A_LO);
  assign rd_hi     = bus_rd_i && (bus_addr_i == A_HI);
  assign commit_lo = pend_lo && tick && seen_lo;
  assign commit_hi = pend_hi && tick && seen_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) tk_sync <= '0;
    else        tk_sync <= {tk_sync[1:0], slow_tick_i};
  end

  always_comb begin
    sec_nxt = sec_q;
    pre_nxt = pre_q;
    if (tick) begin
      pre_nxt = pre_q + 1'b1;
      if (&pre_q) sec_nxt = sec_q + 1'b1;
    end
    if (commit_lo) begin
      sec_nxt[31:0]       = stage_lo;
      sec_nxt[SEC_W-1:32] = sec_q[SEC_W-1:32];
      pre_nxt             = '0;
    end
    if (commit_hi) sec_nxt[SEC_W-1:32] = stage_hi;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= '0;
      pre_q <= '0;
    end else begin
      sec_q <= sec_nxt;
      pre_q <= pre_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_lo <= '0;
      pend_lo  <= 1'b0;
      seen_lo  <= 1'b0;
    end else if (wr_lo) begin
      stage_lo <= bus_wdata_i;
      pend_lo  <= 1'b1;
      seen_lo  <= 1'b0;
    end else if (pend_lo && tick) begin
      if (seen_lo) pend_lo <= 1'b0;
      seen_lo <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_hi <= '0;
      pend_hi  <= 1'b0;
      seen_hi  <= 1'b0;
    end else if (wr_hi) begin
      stage_hi <= bus_wdata_i[HI_W-1:0];
      pend_hi  <= 1'b1;
      seen_hi  <= 1'b0;
    end else if (pend_hi && tick) begin
      if (seen_hi) pend_hi <= 1'b0;
      seen_hi <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      shadow_q <= '0;
      frozen_q <= 1'b0;
    end else begin
      if (wr_ctl) mode_q <= bus_wdata_i[25:24];
      if (rd_lo && mode_q == MODE_FREEZE) begin
        shadow_q <= sec_q[SEC_W-1:32];
        frozen_q <= 1'b1;
      end else if (rd_hi) begin
        frozen_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid_o <= 1'b0;
      bus_rdata_o  <= '0;
    end else begin
      bus_rvalid_o <= bus_rd_i;
      if (bus_rd_i) begin
        case (bus_addr_i)
          A_LO:    bus_rdata_o <= sec_q[31:0];
          A_HI:    bus_rdata_o <= 32'(frozen_q ? shadow_q : sec_q[SEC_W-1:32]);
          A_CTL:   bus_rdata_o <= {6'b0, mode_q, 24'b0};
          A_PEND:  bus_rdata_o <= {30'b0, pend_hi, pend_lo};
          default: bus_rdata_o <= '0;
        endcase
      end
    end
  end

  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_i |=> bus_rvalid_o); // R10
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q != $past(sec_q)) |-> ((sec_q == $past(sec_q) + SEC_W'(1)) || $past(commit_lo || commit_hi))); // R2
  AST_SEC_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sec_q)); // R2
  AST_PEND_LO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_lo) |-> $past(wr_lo)); // R4
  AST_PEND_HI_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_hi) |-> $past(wr_hi)); // R4
  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_q && !(rd_lo && mode_q == MODE_FREEZE)) |=> $stable(shadow_q)); // R8
  AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    commit_lo |=> (pre_q == '0)); // R7
endmodule

// File: tb/sec_counter_split_tb.sv
`timescale 1ns/1ps
module sec_counter_split_tb_top;
  localparam int PRE_W = 3;
  localparam int SEC_TICKS = 1 << PRE_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tk = 1'b0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] e_val;
  string       e_tag;

  always #5 clk = ~clk;

  sec_counter_split #(.PRE_W(PRE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .slow_tick_i(tk),
    .bus_rd_i(rd), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_rvalid_o(rvalid));

  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10: unexpected read data %h, expected none", rdata);
      end else begin
        e_val = exp_q.pop_front();
        e_tag = tag_q.pop_front();
        if (rdata !== e_val) begin
          errors++;
          $display("FAIL %s: got %h expected %h", e_tag, rdata, e_val);
        end
      end
    end
  end

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tk = 1'b1;
      repeat (3) @(negedge clk);
      tk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rvalid !== 1'b0) begin
      errors++; $display("FAIL R1: rvalid got %b expected 0", rvalid);
    end
    rd_exp(8'h08, 32'h0, "R1 low");
    rd_exp(8'h0C, 32'h0, "R1 high");
    rd_exp(8'h68, 32'h0, "R1 pending");
    rd_exp(8'h50, 32'h0, "R1 mode");
    rd_exp(8'h30, 32'h0, "R10 unmapped");

    wr_reg(8'h08, 32'h1234_5678);
    rd_exp(8'h68, 32'h1, "R4 low pending");
    ticks(1);
    rd_exp(8'h08, 32'h0, "R5 old value before second tick");
    rd_exp(8'h68, 32'h1, "R5 still pending");
    ticks(1);
    rd_exp(8'h08, 32'h1234_5678, "R5 committed low");
    rd_exp(8'h68, 32'h0, "R5 pending cleared");

    wr_reg(8'h0C, 32'hABCD_0042);
    rd_exp(8'h68, 32'h2, "R4 high pending");
    ticks(2);
    rd_exp(8'h0C, 32'h0000_0042, "R6 upper bits ignored");

    wr_reg(8'h08, 32'h100);
    ticks(2);
    ticks(SEC_TICKS - 1);
    rd_exp(8'h08, 32'h100, "R7 prescaler restarted");
    ticks(1);
    rd_exp(8'h08, 32'h101, "R2 one second");

    wr_reg(8'h08, 32'hFFFF_FFFF);
    wr_reg(8'h0C, 32'h0000_FFFF);
    rd_exp(8'h68, 32'h3, "R4 both pending");
    ticks(2);
    ticks(SEC_TICKS - 1);
    rd_exp(8'h08, 32'hFFFF_FFFF, "R3 all ones low");
    ticks(1);
    rd_exp(8'h08, 32'h0, "R3 wrap low");
    rd_exp(8'h0C, 32'h0, "R3 wrap high");

    wr_reg(8'h50, 32'hFFFF_FFFF & 32'h0200_0000);
    rd_exp(8'h50, 32'h0200_0000, "R8 mode readback");
    wr_reg(8'h08, 32'hFFFF_FFFF);
    wr_reg(8'h0C, 32'hFFFF_0005);
    ticks(2);
    rd_exp(8'h08, 32'hFFFF_FFFF, "R8 low read");
    ticks(SEC_TICKS);
    rd_exp(8'h0C, 32'h5, "R8 frozen high");
    rd_exp(8'h0C, 32'h6, "R8 released high");

    wr_reg(8'h50, 32'h0);
    rd_exp(8'h50, 32'h0, "R9 mode cleared");
    wr_reg(8'h08, 32'hFFFF_FFFF);
    ticks(2);
    rd_exp(8'h08, 32'hFFFF_FFFF, "R9 low read");
    ticks(SEC_TICKS);
    rd_exp(8'h0C, 32'h7, "R9 live high");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10: got %0d reads outstanding expected 0", exp_q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule